// File: doc/BRIEF.md
# Multi-Cluster Core Power Sequencer

This block keeps an occupancy table of which cores in each of two processor clusters are online. It turns boot and kill requests into ordered power and reset steps. A boot aimed at a cluster with no online core first brings the whole cluster out of power-off: isolation on, resets held, gate opened, resets released, isolation off. Only then does it power the single core. A boot aimed at a cluster that already runs a core goes straight to the core steps.

A kill waits, polling at a fixed interval, for two things: the target core must have announced that it is leaving (a retire pulse clears its table entry), and it must report standby-WFI. The block then closes that core's gate. If this left the cluster empty, it waits for the cluster's L2 standby-WFI, asserts the cluster resets and closes the cluster gate. A core that never becomes idle makes the kill fail with a timeout flag. An L2 that never idles just leaves the cluster powered, and the kill still reports success.

Requests are taken one at a time while the block is idle. Each one ends with a single-cycle response carrying a result code.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: After reset only core 0 of cluster 0 is online and powered. Cluster 0 has its gate open, isolation low and its cluster resets released. Cluster 1 has its gate closed, isolation high and its cluster resets held low. Every core gate is closed except flat index 0, where flat index = cluster*4 + core.
- R2: A boot to a cluster with no online core powers the cluster up before the core. When it completes, the cluster gate is 0, isolation is 0 and the debug-SoC, H and L2 resets are released.
- R3: A cluster gate opens only while that cluster's isolation is high and its H and L2 resets are held low.
- R4: A core gate opens only while that core's power-on reset is held. After a boot the core's power-on and debug resets are released and its gate is open. Its trace reset is released only if the cluster is marked little (default: cluster 0 little, cluster 1 big).
- R5: A boot to a core that is already online responds with code 1 (reject) and changes no output.
- R6: A boot to a cluster that already has an online core never raises that cluster's isolation.
- R7: A kill closes the core's gate and responds with code 0 once the core's entry is cleared and its standby-WFI bit is set. If both do not hold within the timeout (CLK_HZ/1e6*TIMEOUT_US cycles), the kill responds with code 2, raises kill_timeout and leaves the core gate open.
- R8: A kill of the last online core of a cluster waits for that cluster's L2 standby-WFI. It then asserts the debug-SoC, H and L2 resets and closes the cluster gate, and responds with code 0.
- R9: If the L2 standby-WFI does not come within the timeout, the kill still responds with code 0 and kill_timeout stays 0. The cluster gate stays open and the core gate is closed.
- R10: A retire and a boot completion in the same cycle both update the table.
- R11: resp_valid is a one-cycle pulse, and req_ready is high only while no request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_kill | input | 1 | 0 = boot, 1 = kill |
| req_cluster | input | 1 | Target cluster |
| req_core | input | 2 | Target core within the cluster |
| req_ready | output | 1 | Block idle, request accepted |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_code | output | 2 | 0 ok, 1 reject, 2 fail |
| kill_timeout | output | 1 | Core-idle wait expired; held until the next request |
| retire_valid | input | 1 | A core announces it is going offline |
| retire_cluster | input | 1 | Cluster of the retiring core |
| retire_core | input | 2 | Core of the retiring core |
| wfi_core | input | 8 | Per-core standby-WFI status, flat index |
| wfi_l2 | input | 2 | Per-cluster L2 standby-WFI status |
| core_por_n | output | 8 | Core power-on reset, active low |
| core_gate | output | 8 | Core power gate, 1 = off |
| dbg_rst_n | output | 8 | Core debug reset, active low |
| trace_rst_n | output | 8 | Core trace reset, active low |
| dbgsoc_rst_n | output | 2 | Cluster debug-SoC reset, active low |
| hbus_rst_n | output | 2 | Cluster H reset, active low |
| l2_rst_n | output | 2 | Cluster L2 reset, active low |
| coh_inactive | output | 2 | Coherency-inactive isolation control |
| clus_gate | output | 2 | Cluster power gate, 1 = off |

## Verification
Two functions can act in the same cycle: the retire path clears one table entry while a boot completion sets another. The bench provokes this by counting the sequencer's fixed core steps and pulsing a retire of core 1.2 exactly on the edge that marks core 1.3 online. It then judges the outcome through later requests. A second boot of 1.3 must be rejected, which shows the set was kept. A kill of 1.2 must succeed without waiting out the timeout, which shows the clear was kept.

// File: rtl/cpc_pkg.sv
// Shared types for the cluster power sequencer.
package cpc_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_CU_COH, S_CU_POR, S_CU_RST, S_CU_GATE, S_CU_REL, S_CU_COHREL,
        S_CP_RST, S_CP_GATE, S_CP_REL, S_K_WAIT, S_K_GATE, S_L2_WAIT,
        S_CD_RST, S_CD_GATE, S_DONE
    } seq_state_e;

    localparam logic [1:0] RESP_OK     = 2'd0;
    localparam logic [1:0] RESP_REJECT = 2'd1;
    localparam logic [1:0] RESP_FAIL   = 2'd2;
endpackage

// File: rtl/cpc_occupancy.sv
// Per-core online table. One set port (boot completion) and one clear port
// (core retire) may act in the same cycle; set wins on the same index.
// Assumes only the boot core (flat index 0) is online after reset.
module cpc_occupancy #(
    parameter int NCL = 2,
    parameter int NCO = 4,
    localparam int NC = NCL * NCO,
    localparam int IW = $clog2(NC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [NC-1:0] online,
    output logic [NCL-1:0] clus_down
);
    logic [NC-1:0] set_mask, clr_mask;

    // Decode the two update ports into masks.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_en) set_mask[set_idx] = 1'b1;
        if (clr_en) clr_mask[clr_idx] = 1'b1;
    end

    // Apply both updates to the table.
    always_ff @(posedge clk) begin
        if (!rst_n) online <= NC'(1);
        else        online <= (online & ~clr_mask) | set_mask;
    end

    // A cluster is down when none of its entries is set.
    for (genvar c = 0; c < NCL; c++) begin : g_down
        assign clus_down[c] = ~|online[c*NCO +: NCO];
    end
endmodule

// File: rtl/cpc_wait_timer.sv
// Poll-interval and timeout counters for the status waits. Restarted on
// every sequencer state change; the timeout count saturates.
module cpc_wait_timer #(
    parameter int TIMEOUT_CYC = 100000,
    parameter int POLL_CYC    = 16,
    localparam int TW = $clog2(TIMEOUT_CYC + 1),
    localparam int PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic poll_tick,
    output logic expired
);
    logic [TW-1:0] tcnt;
    logic [PW-1:0] pcnt;

    // Count elapsed cycles and poll phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tcnt <= '0;
            pcnt <= '0;
        end else begin
            if (tcnt != TW'(TIMEOUT_CYC)) tcnt <= tcnt + 1'b1;
            pcnt <= (pcnt == PW'(POLL_CYC - 1)) ? '0 : pcnt + 1'b1;
        end
    end

    assign poll_tick = (pcnt == PW'(POLL_CYC - 1));
    assign expired   = (tcnt == TW'(TIMEOUT_CYC));
endmodule

// File: rtl/cpc_sequencer.sv
// Request sequencer: cluster power-up, core power-up, core kill with WFI
// wait, last-core cluster power-down. One step per cycle; all power and
// reset controls are registers. Assumes requests only arrive while idle.
module cpc_sequencer
    import cpc_pkg::*;
#(
    parameter int NCL = 2,
    parameter int NCO = 4,
    parameter logic [NCL-1:0] LITTLE_MASK = 1,
    localparam int NC  = NCL * NCO,
    localparam int IW  = $clog2(NC),
    localparam int CLW = $clog2(NCL),
    localparam int COW = $clog2(NCO)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_kill,
    input  logic [CLW-1:0] req_cluster,
    input  logic [COW-1:0] req_core,
    output logic           req_ready,
    output logic           resp_valid,
    output logic [1:0]     resp_code,
    output logic           kill_timeout,
    input  logic [NC-1:0]  online,
    input  logic [NCL-1:0] clus_down,
    input  logic [NC-1:0]  wfi_core,
    input  logic [NCL-1:0] wfi_l2,
    input  logic           poll_tick,
    input  logic           expired,
    output logic           timer_restart,
    output logic           set_en,
    output logic [IW-1:0]  set_idx,
    output logic [NC-1:0]  core_por_n,
    output logic [NC-1:0]  core_gate,
    output logic [NC-1:0]  dbg_rst_n,
    output logic [NC-1:0]  trace_rst_n,
    output logic [NCL-1:0] dbgsoc_rst_n,
    output logic [NCL-1:0] hbus_rst_n,
    output logic [NCL-1:0] l2_rst_n,
    output logic [NCL-1:0] coh_inactive,
    output logic [NCL-1:0] clus_gate
);
    seq_state_e     state, state_d;
    logic [CLW-1:0] cl_q;
    logic [COW-1:0] co_q;
    logic [1:0]     code_q;
    logic [IW-1:0]  idx, base, ridx;
    logic           little, core_idle, l2_idle;

    assign ridx      = IW'(req_cluster) * IW'(NCO) + IW'(req_core);
    assign base      = IW'(cl_q) * IW'(NCO);
    assign idx       = base + IW'(co_q);
    assign little    = LITTLE_MASK[cl_q];
    assign core_idle = poll_tick && !online[idx] && wfi_core[idx];
    assign l2_idle   = poll_tick && wfi_l2[cl_q];

    // Next-state selection.
    always_comb begin
        state_d = state;
        case (state)
            S_IDLE: if (req_valid) begin
                if (req_kill)                state_d = S_K_WAIT;
                else if (online[ridx])       state_d = S_DONE;
                else if (clus_down[req_cluster]) state_d = S_CU_COH;
                else                         state_d = S_CP_RST;
            end
            S_CU_COH:    state_d = S_CU_POR;
            S_CU_POR:    state_d = S_CU_RST;
            S_CU_RST:    state_d = S_CU_GATE;
            S_CU_GATE:   state_d = S_CU_REL;
            S_CU_REL:    state_d = S_CU_COHREL;
            S_CU_COHREL: state_d = S_CP_RST;
            S_CP_RST:    state_d = S_CP_GATE;
            S_CP_GATE:   state_d = S_CP_REL;
            S_CP_REL:    state_d = S_DONE;
            S_K_WAIT:    if (core_idle) state_d = S_K_GATE;
                         else if (expired) state_d = S_DONE;
            S_K_GATE:    state_d = clus_down[cl_q] ? S_L2_WAIT : S_DONE;
            S_L2_WAIT:   if (l2_idle) state_d = S_CD_RST;
                         else if (expired) state_d = S_DONE;
            S_CD_RST:    state_d = S_CD_GATE;
            S_CD_GATE:   state_d = S_DONE;
            default:     state_d = S_IDLE;
        endcase
    end

    // State register and the control action of each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            cl_q         <= '0;
            co_q         <= '0;
            code_q       <= RESP_OK;
            kill_timeout <= 1'b0;
            core_por_n   <= NC'(1);
            core_gate    <= ~NC'(1);
            dbg_rst_n    <= NC'(1);
            trace_rst_n  <= NC'(1);
            dbgsoc_rst_n <= NCL'(1);
            hbus_rst_n   <= NCL'(1);
            l2_rst_n     <= NCL'(1);
            coh_inactive <= ~NCL'(1);
            clus_gate    <= ~NCL'(1);
        end else begin
            state <= state_d;
            case (state)
                S_IDLE: if (req_valid) begin
                    cl_q         <= req_cluster;
                    co_q         <= req_core;
                    kill_timeout <= 1'b0;
                    code_q       <= (!req_kill && online[ridx]) ? RESP_REJECT : RESP_OK;
                end
                S_CU_COH: coh_inactive[cl_q] <= 1'b1;
                S_CU_POR: core_por_n[base +: NCO] <= '0;
                S_CU_RST: begin
                    dbgsoc_rst_n[cl_q] <= 1'b0;
                    hbus_rst_n[cl_q]   <= 1'b0;
                    l2_rst_n[cl_q]     <= 1'b0;
                    dbg_rst_n[base +: NCO] <= '0;
                    if (little) trace_rst_n[base +: NCO] <= '0;
                end
                S_CU_GATE: clus_gate[cl_q] <= 1'b0;
                S_CU_REL: begin
                    dbgsoc_rst_n[cl_q] <= 1'b1;
                    hbus_rst_n[cl_q]   <= 1'b1;
                    l2_rst_n[cl_q]     <= 1'b1;
                end
                S_CU_COHREL: coh_inactive[cl_q] <= 1'b0;
                S_CP_RST: begin
                    core_por_n[idx] <= 1'b0;
                    dbg_rst_n[idx]  <= 1'b0;
                    if (little) trace_rst_n[idx] <= 1'b0;
                end
                S_CP_GATE: core_gate[idx] <= 1'b0;
                S_CP_REL: begin
                    core_por_n[idx] <= 1'b1;
                    dbg_rst_n[idx]  <= 1'b1;
                    if (little) trace_rst_n[idx] <= 1'b1;
                end
                S_K_WAIT: if (!core_idle && expired) begin
                    code_q       <= RESP_FAIL;
                    kill_timeout <= 1'b1;
                end
                S_K_GATE: core_gate[idx] <= 1'b1;
                S_CD_RST: begin
                    dbgsoc_rst_n[cl_q] <= 1'b0;
                    hbus_rst_n[cl_q]   <= 1'b0;
                    l2_rst_n[cl_q]     <= 1'b0;
                end
                S_CD_GATE: clus_gate[cl_q] <= 1'b1;
                default: ;
            endcase
        end
    end

    assign req_ready     = (state == S_IDLE);
    assign resp_valid    = (state == S_DONE);
    assign resp_code     = code_q;
    assign timer_restart = (state_d != state);
    assign set_en        = (state == S_CP_REL);
    assign set_idx       = idx;
endmodule

// File: rtl/cluster_pwr_ctrl.sv
// Top level: occupancy table, wait timer and sequencer. Timeout budget in
// cycles is derived from the clock frequency and a microsecond budget.
// Assumes at least two clusters and a power-of-two core count.
module cluster_pwr_ctrl #(
    parameter int NUM_CLUSTERS      = 2,
    parameter int CORES_PER_CLUSTER = 4,
    parameter int CLK_HZ            = 200_000_000,
    parameter int TIMEOUT_US        = 100_000,
    parameter int POLL_CYC          = 64,
    parameter logic [NUM_CLUSTERS-1:0] LITTLE_MASK = 1,
    localparam int NC          = NUM_CLUSTERS * CORES_PER_CLUSTER,
    localparam int IW          = $clog2(NC),
    localparam int CLW         = $clog2(NUM_CLUSTERS),
    localparam int COW         = $clog2(CORES_PER_CLUSTER),
    localparam int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_kill,
    input  logic [CLW-1:0]          req_cluster,
    input  logic [COW-1:0]          req_core,
    output logic                    req_ready,
    output logic                    resp_valid,
    output logic [1:0]              resp_code,
    output logic                    kill_timeout,
    input  logic                    retire_valid,
    input  logic [CLW-1:0]          retire_cluster,
    input  logic [COW-1:0]          retire_core,
    input  logic [NC-1:0]           wfi_core,
    input  logic [NUM_CLUSTERS-1:0] wfi_l2,
    output logic [NC-1:0]           core_por_n,
    output logic [NC-1:0]           core_gate,
    output logic [NC-1:0]           dbg_rst_n,
    output logic [NC-1:0]           trace_rst_n,
    output logic [NUM_CLUSTERS-1:0] dbgsoc_rst_n,
    output logic [NUM_CLUSTERS-1:0] hbus_rst_n,
    output logic [NUM_CLUSTERS-1:0] l2_rst_n,
    output logic [NUM_CLUSTERS-1:0] coh_inactive,
    output logic [NUM_CLUSTERS-1:0] clus_gate
);
    logic [NC-1:0]           online;
    logic [NUM_CLUSTERS-1:0] clus_down;
    logic                    set_en, timer_restart, poll_tick, expired;
    logic [IW-1:0]           set_idx, clr_idx;

    assign clr_idx = IW'(retire_cluster) * IW'(CORES_PER_CLUSTER) + IW'(retire_core);

    cpc_occupancy #(.NCL(NUM_CLUSTERS), .NCO(CORES_PER_CLUSTER)) u_occ (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en), .set_idx(set_idx),
        .clr_en(retire_valid), .clr_idx(clr_idx),
        .online(online), .clus_down(clus_down)
    );

    cpc_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .POLL_CYC(POLL_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(timer_restart),
        .poll_tick(poll_tick), .expired(expired)
    );

    cpc_sequencer #(.NCL(NUM_CLUSTERS), .NCO(CORES_PER_CLUSTER),
                    .LITTLE_MASK(LITTLE_MASK)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kill(req_kill),
        .req_cluster(req_cluster), .req_core(req_core),
        .req_ready(req_ready), .resp_valid(resp_valid),
        .resp_code(resp_code), .kill_timeout(kill_timeout),
        .online(online), .clus_down(clus_down),
        .wfi_core(wfi_core), .wfi_l2(wfi_l2),
        .poll_tick(poll_tick), .expired(expired),
        .timer_restart(timer_restart),
        .set_en(set_en), .set_idx(set_idx),
        .core_por_n(core_por_n), .core_gate(core_gate),
        .dbg_rst_n(dbg_rst_n), .trace_rst_n(trace_rst_n),
        .dbgsoc_rst_n(dbgsoc_rst_n), .hbus_rst_n(hbus_rst_n),
        .l2_rst_n(l2_rst_n), .coh_inactive(coh_inactive),
        .clus_gate(clus_gate)
    );
endmodule

// File: rtl/cpc_checker.sv
// Ordering and handshake properties for cluster_pwr_ctrl, bound to it.
module cpc_checker #(
    parameter int NCL = 2,
    parameter int NCO = 4,
    localparam int NC = NCL * NCO
) (
    input logic           clk,
    input logic           rst_n,
    input logic           resp_valid,
    input logic [1:0]     resp_code,
    input logic           kill_timeout,
    input logic           req_ready,
    input logic [NC-1:0]  core_por_n,
    input logic [NC-1:0]  core_gate,
    input logic [NCL-1:0] hbus_rst_n,
    input logic [NCL-1:0] l2_rst_n,
    input logic [NCL-1:0] dbgsoc_rst_n,
    input logic [NCL-1:0] coh_inactive,
    input logic [NCL-1:0] clus_gate
);
    for (genvar c = 0; c < NCL; c++) begin : g_cl
        assert_gate_open_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(clus_gate[c]) |-> (coh_inactive[c] && !hbus_rst_n[c] && !l2_rst_n[c]));
        assert_gate_close_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(clus_gate[c]) |-> (!hbus_rst_n[c] && !l2_rst_n[c] && !dbgsoc_rst_n[c]));
    end

    for (genvar i = 0; i < NC; i++) begin : g_core
        assert_core_gate_open_in_por_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(core_gate[i]) |-> !core_por_n[i]);
    end

    assert_resp_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    assert_timeout_means_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kill_timeout) |-> (resp_valid && resp_code == 2'd2));
    assert_resp_then_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);
endmodule

bind cluster_pwr_ctrl cpc_checker #(.NCL(NUM_CLUSTERS), .NCO(CORES_PER_CLUSTER)) u_chk (
    .clk(clk), .rst_n(rst_n), .resp_valid(resp_valid), .resp_code(resp_code),
    .kill_timeout(kill_timeout), .req_ready(req_ready),
    .core_por_n(core_por_n), .core_gate(core_gate),
    .hbus_rst_n(hbus_rst_n), .l2_rst_n(l2_rst_n), .dbgsoc_rst_n(dbgsoc_rst_n),
    .coh_inactive(coh_inactive), .clus_gate(clus_gate)
);

// File: tb/cluster_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module cluster_pwr_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_kill = 1'b0;
    logic req_cluster = 1'b0;
    logic [1:0] req_core = 2'd0;
    logic req_ready, resp_valid, kill_timeout;
    logic [1:0] resp_code;
    logic retire_valid = 1'b0, retire_cluster = 1'b0;
    logic [1:0] retire_core = 2'd0;
    logic [7:0] wfi_core = 8'h00;
    logic [1:0] wfi_l2 = 2'b00;
    logic [7:0] core_por_n, core_gate, dbg_rst_n, trace_rst_n;
    logic [1:0] dbgsoc_rst_n, hbus_rst_n, l2_rst_n, coh_inactive, clus_gate;

    int total = 0;
    int bad = 0;
    logic [1:0] code;

    // Monitors for ordering checks.
    logic       mon_coh0_rose = 1'b0;
    logic       gate1_prev = 1'b1;
    logic       gate1_fell_seen = 1'b0;
    logic       gate1_fell_coh = 1'b0;
    logic       gate1_fell_h = 1'b1;

    always #2.5 clk = ~clk;

    cluster_pwr_ctrl #(.CLK_HZ(1_000_000), .TIMEOUT_US(40), .POLL_CYC(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kill(req_kill),
        .req_cluster(req_cluster), .req_core(req_core), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_code(resp_code), .kill_timeout(kill_timeout),
        .retire_valid(retire_valid), .retire_cluster(retire_cluster),
        .retire_core(retire_core), .wfi_core(wfi_core), .wfi_l2(wfi_l2),
        .core_por_n(core_por_n), .core_gate(core_gate), .dbg_rst_n(dbg_rst_n),
        .trace_rst_n(trace_rst_n), .dbgsoc_rst_n(dbgsoc_rst_n),
        .hbus_rst_n(hbus_rst_n), .l2_rst_n(l2_rst_n),
        .coh_inactive(coh_inactive), .clus_gate(clus_gate)
    );

    always @(negedge clk) begin
        if (rst_n && coh_inactive[0]) mon_coh0_rose <= 1'b1;
        if (rst_n && gate1_prev && !clus_gate[1]) begin
            gate1_fell_seen <= 1'b1;
            gate1_fell_coh  <= coh_inactive[1];
            gate1_fell_h    <= hbus_rst_n[1];
        end
        gate1_prev <= clus_gate[1];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Issue one request and wait for its response; check the pulse shape.
    task automatic do_req(input bit kill, input bit cl, input logic [1:0] co,
                          output logic [1:0] rc);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_kill = kill; req_cluster = cl; req_core = co;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!resp_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        rc = resp_code;
        @(negedge clk);
        check(!resp_valid && req_ready, "R11 pulse/ready", {resp_valid, req_ready}, 1);
    endtask

    task automatic retire(input bit cl, input logic [1:0] co);
        @(negedge clk);
        retire_valid = 1'b1; retire_cluster = cl; retire_core = co;
        @(negedge clk);
        retire_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(clus_gate == 2'b10, "R1 clus_gate", clus_gate, 2);
        check(coh_inactive == 2'b10, "R1 coh", coh_inactive, 2);
        check(hbus_rst_n == 2'b01 && l2_rst_n == 2'b01 && dbgsoc_rst_n == 2'b01,
              "R1 cluster resets", hbus_rst_n, 1);
        check(core_gate == 8'hFE, "R1 core_gate", core_gate, 8'hFE);
        check(core_por_n == 8'h01, "R1 core_por_n", core_por_n, 1);
        check(req_ready && !resp_valid, "R11 idle after reset", req_ready, 1);
    endtask

    task automatic t_reject();
        do_req(1'b0, 1'b0, 2'd0, code);
        check(code == 2'd1, "R5 reject code", code, 1);
        check(core_gate == 8'hFE && clus_gate == 2'b10, "R5 outputs unchanged", core_gate, 8'hFE);
    endtask

    task automatic t_boot_same_cluster();
        mon_coh0_rose = 1'b0;
        do_req(1'b0, 1'b0, 2'd1, code);
        check(code == 2'd0, "R6 boot ok", code, 0);
        check(!mon_coh0_rose, "R6 no isolation", mon_coh0_rose, 0);
        check(!core_gate[1] && core_por_n[1] && dbg_rst_n[1], "R4 core 0.1 up",
              {core_gate[1], core_por_n[1], dbg_rst_n[1]}, 3);
        check(trace_rst_n[1], "R4 little trace released", trace_rst_n[1], 1);
    endtask

    task automatic t_boot_new_cluster();
        do_req(1'b0, 1'b1, 2'd2, code);
        check(code == 2'd0, "R2 boot ok", code, 0);
        check(!clus_gate[1] && !coh_inactive[1], "R2 cluster up", {clus_gate[1], coh_inactive[1]}, 0);
        check(hbus_rst_n[1] && l2_rst_n[1] && dbgsoc_rst_n[1], "R2 resets released",
              {hbus_rst_n[1], l2_rst_n[1], dbgsoc_rst_n[1]}, 7);
        check(gate1_fell_seen && gate1_fell_coh && !gate1_fell_h, "R3 gate opened isolated",
              {gate1_fell_seen, gate1_fell_coh, gate1_fell_h}, 6);
        check(!core_gate[6] && core_por_n[6], "R4 core 1.2 up", core_gate[6], 0);
        check(!trace_rst_n[6], "R4 big trace untouched", trace_rst_n[6], 0);
    endtask

    task automatic t_kill_timeout();
        wfi_core[1] = 1'b1;
        do_req(1'b1, 1'b0, 2'd1, code);
        check(code == 2'd2, "R7 fail code", code, 2);
        check(kill_timeout, "R7 timeout flag", kill_timeout, 1);
        check(!core_gate[1], "R7 gate stays open", core_gate[1], 0);
    endtask

    task automatic t_kill_ok();
        retire(1'b0, 2'd1);
        do_req(1'b1, 1'b0, 2'd1, code);
        check(code == 2'd0 && !kill_timeout, "R7 kill ok", code, 0);
        check(core_gate[1] && !clus_gate[0], "R7 core gated, cluster kept",
              {core_gate[1], clus_gate[0]}, 2);
    endtask

    // Retire 1.2 on the same edge that marks 1.3 online (R10).
    task automatic t_same_cycle();
        @(negedge clk);
        req_valid = 1'b1; req_kill = 1'b0; req_cluster = 1'b1; req_core = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        retire_valid = 1'b1; retire_cluster = 1'b1; retire_core = 2'd2;
        @(negedge clk);
        retire_valid = 1'b0;
        check(resp_valid && resp_code == 2'd0, "R10 boot 1.3 done", resp_code, 0);
        @(negedge clk);
        do_req(1'b0, 1'b1, 2'd3, code);
        check(code == 2'd1, "R10 set kept", code, 1);
        wfi_core[6] = 1'b1;
        do_req(1'b1, 1'b1, 2'd2, code);
        check(code == 2'd0 && core_gate[6], "R10 clear kept", code, 0);
        check(!clus_gate[1], "R10 cluster still up", clus_gate[1], 0);
    endtask

    task automatic t_l2_timeout();
        retire(1'b1, 2'd3);
        wfi_core[7] = 1'b1;
        wfi_l2[1] = 1'b0;
        do_req(1'b1, 1'b1, 2'd3, code);
        check(code == 2'd0 && !kill_timeout, "R9 ok despite l2 timeout", {code, kill_timeout}, 0);
        check(!clus_gate[1] && core_gate[7], "R9 cluster left on", {clus_gate[1], core_gate[7]}, 1);
    endtask

    task automatic t_last_core();
        do_req(1'b0, 1'b1, 2'd0, code);
        check(code == 2'd0 && !core_gate[4], "R2 re-power cluster 1", code, 0);
        retire(1'b1, 2'd0);
        wfi_core[4] = 1'b1;
        wfi_l2[1] = 1'b1;
        do_req(1'b1, 1'b1, 2'd0, code);
        check(code == 2'd0, "R8 kill ok", code, 0);
        check(clus_gate[1] && !hbus_rst_n[1] && !l2_rst_n[1] && !dbgsoc_rst_n[1],
              "R8 cluster down", clus_gate[1], 1);
        check(!clus_gate[0], "R8 other cluster untouched", clus_gate[0], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject();
        t_boot_same_cluster();
        t_boot_new_cluster();
        t_kill_timeout();
        t_kill_ok();
        t_same_cycle();
        t_l2_timeout();
        t_last_core();
        summary();
    end
endmodule